// File: doc/BRIEF.md
# Opcode-Selected 8-bit ALU with Carry Flag

This block is the arithmetic and logic stage of a small accumulator-style processor. It takes two register operands, A and B, and a 4-bit function code, which is the low nibble of an ALU-class opcode. From these it forms one result: a sum, a difference, a bitwise logic value, the complement of B, or A shifted by one bit. That result goes onto the shared data bus only while the ALU-active strobe is high. Bit 0 of the function code acts as a B-invert line. B passes through an XOR stage with this bit, and the same bit is the adder's carry-in, so one adder serves both addition and two's-complement subtraction. The INV operation reuses that XOR path.

A 4-bit status register holds the carry flag in bit 0, which later conditional jumps use. Only ADD, SUB and CMP update the flag. CMP compares A and B by magnitude and drives nothing onto the bus. The flag is captured on the rising edge that ends the cycle in which the result is driven, so it lags the result by one cycle.

Top module: `opcode_alu`

## Requirements
- R1: Function code 0x0 (ADD) drives (A + B) mod 256.
- R2: Function code 0x1 (SUB) drives (A - B) mod 256, formed as A + ~B + 1.
- R3: Function codes 0x2, 0x4 and 0x6 drive A AND B, A OR B and A XOR B.
- R4: Function code 0xB (INV) drives the bitwise complement of B.
- R5: Function code 0xC drives A shifted left by one bit, and 0xE drives A shifted right by one bit. The vacated bit is 0 in both cases.
- R6: The unlisted codes 0x3, 0x5, 0x7, 0x9, 0xA, 0xD and 0xF drive 0x00 and leave the carry flag unchanged.
- R7: bus_oe_o is high exactly when alu_en_i is high and the function code is not 0x8 (CMP). While bus_oe_o is low, bus_o reads 0x00.
- R8: With ADD and alu_en_i high, carry (status_o bit 0) takes bit 8 of the true sum at the next rising edge. For example, 0xEB + 0xAD drives 0x98 and sets carry.
- R9: With SUB or CMP (0x8) and alu_en_i high, carry takes (A >= B, unsigned) at the next rising edge.
- R10: Carry does not change at an edge where alu_en_i is low or where the function code is anything other than 0x0, 0x1 or 0x8.
- R11: Carry lags the result. During the cycle in which the result is driven, status_o still shows the previous flag, and the new value appears only after the rising edge.
- R12: rst_ni low clears status_o to 0. Bits 3:1 of status_o always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the status register updates on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the status register |
| alu_en_i | input | 1 | ALU-active strobe |
| func_i | input | 4 | Function code (low nibble of the opcode) |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| bus_o | output | 8 | Result toward the shared bus, 0x00 when not enabled |
| bus_oe_o | output | 1 | Bus output enable; low models high impedance |
| status_o | output | 4 | Status register; bit 0 is carry |

## Verification
The carry assertions assume that func_i, a_i, b_i and alu_en_i are stable from the falling edge up to the rising edge that samples them. Under that assumption, the sampled operands are the ones that produced the flag. The bench changes its inputs only just after falling edges, and it holds them through the next rising edge. Random codes cover all sixteen nibbles, and the strobe is low about one cycle in five, so the paths that hold the flag and disable the bus are exercised regularly.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    FN_ADD = 4'h0,
    FN_SUB = 4'h1,
    FN_AND = 4'h2,
    FN_OR  = 4'h4,
    FN_XOR = 4'h6,
    FN_CMP = 4'h8,
    FN_INV = 4'hB,
    FN_LSL = 4'hC,
    FN_LSR = 4'hE
  } alu_func_e;

  localparam int unsigned CARRY_BIT = 0;
endpackage

// File: rtl/alu_b_invert.sv
module alu_b_invert #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] b_i,
  input  logic         inv_i,
  output logic [W-1:0] b_o
);
  for (genvar i = 0; i < W; i++) begin : g_xor
    assign b_o[i] = b_i[i] ^ inv_i;
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;
  assign c[0] = cin_i;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end
  assign cout_o = c[W];
endmodule

// File: rtl/alu_magnitude_cmp.sv
module alu_magnitude_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         ge_o
);
  // MSB-first scan: first differing bit decides
  logic [W:0] dec;
  logic [W:0] res;
  assign dec[W] = 1'b0;
  assign res[W] = 1'b1;
  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    assign dec[i] = dec[i+1] | (a_i[i] ^ b_i[i]);
    assign res[i] = dec[i+1] ? res[i+1] : ((a_i[i] ^ b_i[i]) ? a_i[i] : res[i+1]);
  end
  assign ge_o = res[0];
endmodule

// File: rtl/alu_status.sv
module alu_status #(
  parameter int unsigned SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic          carry_i,
  output logic [SW-1:0] status_o
);
  logic carry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    carry_q <= 1'b0;
    else if (upd_i) carry_q <= carry_i;
  end

  assign status_o = {{(SW-1){1'b0}}, carry_q};

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(status_o));

  assert_capture_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> status_o[0] == $past(carry_i));
endmodule

// File: rtl/opcode_alu.sv
module opcode_alu
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned STATUS_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alu_en_i,
  input  logic [3:0]          func_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  output logic [DATA_W-1:0]   bus_o,
  output logic                bus_oe_o,
  output logic [STATUS_W-1:0] status_o
);
  localparam logic [DATA_W-1:0] ZERO = '0;

  alu_func_e         fn;
  logic              inv_b;
  logic [DATA_W-1:0] b_sel;
  logic [DATA_W-1:0] sum;
  logic              cout;
  logic              a_ge_b;
  logic [DATA_W-1:0] result;
  logic              flag_upd;
  logic              flag_nxt;

  assign fn    = alu_func_e'(func_i);
  assign inv_b = func_i[0];

  alu_b_invert #(.W(DATA_W)) u_binv (
    .b_i  (b_i),
    .inv_i(inv_b),
    .b_o  (b_sel)
  );

  alu_adder #(.W(DATA_W)) u_add (
    .a_i   (a_i),
    .b_i   (b_sel),
    .cin_i (inv_b),
    .sum_o (sum),
    .cout_o(cout)
  );

  alu_magnitude_cmp #(.W(DATA_W)) u_cmp (
    .a_i (a_i),
    .b_i (b_i),
    .ge_o(a_ge_b)
  );

  always_comb begin
    result   = ZERO;
    flag_upd = 1'b0;
    flag_nxt = cout;
    unique case (fn)
      FN_ADD, FN_SUB: begin result = sum; flag_upd = 1'b1; end
      FN_AND:         result = a_i & b_i;
      FN_OR:          result = a_i | b_i;
      FN_XOR:         result = a_i ^ b_i;
      FN_CMP:         begin flag_upd = 1'b1; flag_nxt = a_ge_b; end
      FN_INV:         result = b_sel;
      FN_LSL:         result = {a_i[DATA_W-2:0], 1'b0};
      FN_LSR:         result = {1'b0, a_i[DATA_W-1:1]};
      default:        result = ZERO;
    endcase
  end

  assign bus_oe_o = alu_en_i && (fn != FN_CMP);
  assign bus_o    = bus_oe_o ? result : ZERO;

  alu_status #(.SW(STATUS_W)) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (alu_en_i && flag_upd),
    .carry_i (flag_nxt),
    .status_o(status_o)
  );

  assert_add_carry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_en_i && func_i == 4'h0) |=>
      status_o[CARRY_BIT] == ((DATA_W+1)'($past(a_i)) + (DATA_W+1)'($past(b_i)) > (DATA_W+1)'(2**DATA_W - 1)));

  assert_ge_carry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_en_i && (func_i == 4'h1 || func_i == 4'h8)) |=>
      status_o[CARRY_BIT] == ($past(a_i) >= $past(b_i)));

  assert_idle_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alu_en_i |=> $stable(status_o));

  assert_bus_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> bus_o == ZERO);

  assert_upper_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[STATUS_W-1:1] == '0);
endmodule

// File: tb/sim_opcode_alu.sv
module sim_opcode_alu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] fn = 4'h0;
  logic [7:0] a = 8'h00;
  logic [7:0] b = 8'h00;
  logic [7:0] bus;
  logic       oe;
  logic [3:0] st;

  int checks = 0;
  int errors = 0;
  logic model_c = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opcode_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .alu_en_i(en), .func_i(fn),
    .a_i(a), .b_i(b), .bus_o(bus), .bus_oe_o(oe), .status_o(st)
  );

  function automatic logic [7:0] exp_res(input logic [3:0] f, input logic [7:0] x, input logic [7:0] y);
    case (f)
      4'h0: return x + y;
      4'h1: return x - y;
      4'h2: return x & y;
      4'h4: return x | y;
      4'h6: return x ^ y;
      4'hB: return ~y;
      4'hC: return {x[6:0], 1'b0};
      4'hE: return {1'b0, x[7:1]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_flag(input logic [3:0] f, input logic [7:0] x, input logic [7:0] y, input logic old);
    case (f)
      4'h0: return ({1'b0, x} + {1'b0, y}) > 9'd255;
      4'h1, 4'h8: return x >= y;
      default: return old;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive after negedge, check bus mid-cycle, check flag after posedge
  task automatic op(input string req, input logic e, input logic [3:0] f, input logic [7:0] x, input logic [7:0] y);
    logic [7:0] er;
    logic eo;
    @(negedge clk);
    en = e; fn = f; a = x; b = y;
    #1;
    eo = e && (f != 4'h8);
    er = eo ? exp_res(f, x, y) : 8'h00;
    chk({req, " bus"}, bus, er);
    chk({req, " oe R7"}, {7'd0, oe}, {7'd0, eo});
    chk({req, " lag R11"}, {4'd0, st}, {7'd0, model_c});
    if (e) model_c = exp_flag(f, x, y, model_c);
    @(posedge clk);
    #1;
    chk({req, " flag R12"}, {4'd0, st}, {7'd0, model_c});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20170520));
    #(CLK_PERIOD * 2 + 1);
    chk("reset R12", {4'd0, st}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    op("R8 add carry", 1'b1, 4'h0, 8'hEB, 8'hAD);
    chk("R8 sticky", {7'd0, st[0]}, 8'h01);
    op("R6 unlisted keeps", 1'b1, 4'h5, 8'h12, 8'h34);
    chk("R6 carry kept", {7'd0, st[0]}, 8'h01);
    op("R2 R9 sub equal", 1'b1, 4'h1, 8'h05, 8'h05);
    op("R2 R9 sub borrow", 1'b1, 4'h1, 8'h03, 8'h05);
    chk("R9 borrow clears", {7'd0, st[0]}, 8'h00);
    op("R9 cmp equal", 1'b1, 4'h8, 8'h40, 8'h40);
    op("R9 cmp less", 1'b1, 4'h8, 8'h3F, 8'h40);
    op("R1 add no carry", 1'b1, 4'h0, 8'h7F, 8'h01);
    op("R11 add lag", 1'b1, 4'h0, 8'hFF, 8'h01);
    op("R10 idle add", 1'b0, 4'h1, 8'h00, 8'h01);
    op("R10 logic no flag", 1'b1, 4'h2, 8'h00, 8'hFF);
    op("R3 and", 1'b1, 4'h2, 8'hF0, 8'h3C);
    op("R3 or", 1'b1, 4'h4, 8'hF0, 8'h0C);
    op("R3 xor", 1'b1, 4'h6, 8'hFF, 8'h5A);
    op("R4 inv", 1'b1, 4'hB, 8'h00, 8'hA5);
    op("R5 lsl", 1'b1, 4'hC, 8'h81, 8'h00);
    op("R5 lsr", 1'b1, 4'hE, 8'h81, 8'h00);
    op("R7 disabled", 1'b0, 4'h4, 8'hFF, 8'hFF);

    for (int i = 0; i < 600; i++) begin
      op("random R1 R3 R6", ($urandom % 5) != 0, 4'($urandom), 8'($urandom), 8'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule